// File: doc/BRIEF.md
# Over-Current Retry Protection Sequencer

This block is the per-channel protection controller for a low-side output driver. It watches the channel's on/off command, a raw over-current comparator, an over-temperature flag and a retry-mode bit. From these it decides, cycle by cycle, whether the driver may conduct. It also keeps a sticky fault flag that the diagnostic logic reads.

In retry mode, an over-current moves the channel into a current-limit window of fixed length. The driver stays on during that window. A cool-off period follows, 100 times as long, with the driver off. The channel then tries again, and this repeats for as long as the over-current persists. In latch mode, an over-current turns the driver off until the command is dropped and raised again. Over-temperature overrides everything. The analog limiting, sensing and serial transport sit outside this block.

Top module: `ocp_retry_seq`

## Requirements
- R1: After reset the driver is off, the fault flag is 0 and the retry-mode bit is 1, so retry mode is active until it is written.
- R2: With no fault present, the driver turns on at the first clock edge after the command rises and turns off at the first clock edge after it falls.
- R3: The raw over-current input passes through a two-flop synchronizer. With the driver on, current limit (`limit_o`=1, driver still on) starts 3 clock edges after the raw input rises and lasts exactly LIMIT_CYCLES cycles.
- R4: In retry mode, current limit is followed by a cool-off of exactly 100×LIMIT_CYCLES cycles with the driver off, after which the driver turns on again.
- R5: If the over-current is still present when the driver retries, the driver is on for one cycle and then enters a new current-limit and cool-off cycle. This repeats indefinitely.
- R6: Dropping the command during current limit or cool-off turns the driver off at the next edge and ends the retry sequence.
- R7: In latch mode (retry bit 0), an over-current seen while on turns the driver off at the next edge. It stays off while the command is held, even after the over-current clears, and comes back on only after the command goes low and then high.
- R8: Over-temperature turns the driver off at the next edge from any state, including current limit. The driver turns on again 2 edges after the flag clears, if the command is high.
- R9: The over-current input is ignored while the driver is off. It sets no fault and starts no limit.
- R10: The fault flag is set by an over-current seen while the driver is on, or by over-temperature. It stays set until a clear pulse arrives, and the clear takes effect only if neither condition is present in that cycle.
- R11: A pulse on `retry_wr_i` loads `retry_val_i` into the retry-mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_on_i | input | 1 | Channel on/off command |
| oc_raw_i | input | 1 | Raw over-current comparator output, asynchronous |
| ot_i | input | 1 | Over-temperature flag, synchronous |
| retry_wr_i | input | 1 | Write strobe for the retry-mode bit |
| retry_val_i | input | 1 | Value written: 1 retry, 0 latch-off |
| fault_clr_i | input | 1 | Clear pulse for the fault flag, from a diagnostic read |
| drv_en_o | output | 1 | Driver conduction enable |
| limit_o | output | 1 | Channel is in current limit |
| fault_o | output | 1 | Sticky fault flag |

## Verification
A wrong state register or a wrong state transition shows up at `drv_en_o` and `limit_o` within one cycle. This includes a current limit that never ends, a latch that releases on its own, or an over-temperature that loses its priority. A miscounted timer shows up only when a window ends: the current-limit length is wrong after a few cycles, and the cool-off length is wrong after hundreds. For that reason the bench measures every high and low run in cycles, across several consecutive retries, rather than sampling at fixed points. A fault flag that clears when it should not, or sets from an over-current while the driver is off, is visible at `fault_o` directly after the pulse or stimulus.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_ON    = 3'd1,
    ST_LIMIT = 3'd2,
    ST_COOL  = 3'd3,
    ST_LATCH = 3'd4,
    ST_HOT   = 3'd5
  } ocp_state_e;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ocp_timer.sv
module ocp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ocp_fault_flag.sv
module ocp_fault_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins: a clear with the condition still active is refused
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R10
  AST_FAULT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R10
endmodule

// File: rtl/ocp_retry_seq.sv
module ocp_retry_seq
  import ocp_pkg::*;
#(
  parameter int LIMIT_CYCLES = 50,
  parameter int OFF_MULT     = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_on_i,
  input  logic oc_raw_i,
  input  logic ot_i,
  input  logic retry_wr_i,
  input  logic retry_val_i,
  input  logic fault_clr_i,
  output logic drv_en_o,
  output logic limit_o,
  output logic fault_o
);
  localparam int OFF_CYCLES = LIMIT_CYCLES * OFF_MULT;
  localparam int CNT_W      = $clog2(OFF_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIM_LAST = CNT_W'(LIMIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYCLES - 1);

  ocp_state_e       state_q, state_d;
  logic             oc_s;
  logic             retry_q;
  logic [CNT_W-1:0] cnt;
  logic             tmr_clr, tmr_en;

  ocp_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (oc_raw_i),
    .q_o   (oc_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         retry_q <= 1'b1;
    else if (retry_wr_i) retry_q <= retry_val_i;
  end

  always_comb begin
    state_d = state_q;
    if (ot_i) begin
      state_d = ST_HOT;
    end else begin
      unique case (state_q)
        ST_OFF:   if (cmd_on_i) state_d = ST_ON;
        ST_ON: begin
          if (!cmd_on_i)    state_d = ST_OFF;
          else if (oc_s)    state_d = retry_q ? ST_LIMIT : ST_LATCH;
        end
        ST_LIMIT: begin
          if (!cmd_on_i)            state_d = ST_OFF;
          else if (cnt == LIM_LAST) state_d = ST_COOL;
        end
        ST_COOL: begin
          if (!cmd_on_i)            state_d = ST_OFF;
          else if (cnt == OFF_LAST) state_d = ST_ON;
        end
        ST_LATCH: if (!cmd_on_i) state_d = ST_OFF;
        ST_HOT:   state_d = ST_OFF;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign tmr_clr = (state_d != state_q);
  assign tmr_en  = (state_q == ST_LIMIT) || (state_q == ST_COOL);

  ocp_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .cnt_o (cnt)
  );

  assign drv_en_o = (state_q == ST_ON) || (state_q == ST_LIMIT);
  assign limit_o  = (state_q == ST_LIMIT);

  ocp_fault_flag u_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ot_i || (oc_s && drv_en_o)),
    .clr_i (fault_clr_i),
    .flag_o(fault_o)
  );

  AST_OT_FORCES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |=> (!drv_en_o && !limit_o)); // R8
  AST_CMD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_on_i |=> !drv_en_o); // R6
  AST_LIMIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LIMIT) |-> (cnt < CNT_W'(LIMIT_CYCLES))); // R3
  AST_COOL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COOL) |-> (cnt < CNT_W'(OFF_CYCLES))); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH && cmd_on_i && !ot_i) |=> !drv_en_o); // R7
  AST_OFF_IGNORES_OC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_en_o && !cmd_on_i && !ot_i) |=> !limit_o); // R9
endmodule

// File: tb/sim_ocp_retry_seq.sv
module sim_ocp_retry_seq;
  localparam int L   = 3;
  localparam int OFF = 100 * L;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_on_i = 1'b0, oc_raw_i = 1'b0, ot_i = 1'b0;
  logic retry_wr_i = 1'b0, retry_val_i = 1'b0, fault_clr_i = 1'b0;
  logic drv_en_o, limit_o, fault_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ocp_retry_seq #(.LIMIT_CYCLES(L), .OFF_MULT(100)) u0 (
    .clk_i, .rst_ni, .cmd_on_i, .oc_raw_i, .ot_i, .retry_wr_i,
    .retry_val_i, .fault_clr_i, .drv_en_o, .limit_o, .fault_o
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_hi_limit(output int n);
    n = 0;
    while (limit_o && n < 10 * OFF) begin n++; tick(); end
  endtask

  task automatic run_lo_drv(output int n);
    n = 0;
    while (!drv_en_o && n < 10 * OFF) begin n++; tick(); end
  endtask

  task automatic clr_pulse();
    fault_clr_i = 1'b1; tick(); fault_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    tick(2);
    // R1 reset state
    chk("R1 drv", drv_en_o, 0);
    chk("R1 fault", fault_o, 0);
    rst_ni = 1'b1; tick();

    // R2 plain on/off
    cmd_on_i = 1'b1; tick(); chk("R2 on", drv_en_o, 1);
    cmd_on_i = 1'b0; tick(); chk("R2 off", drv_en_o, 0);
    cmd_on_i = 1'b1; tick(); chk("R2 on again", drv_en_o, 1);

    // R3 sync latency; retry active by default (R1)
    oc_raw_i = 1'b1; tick(2);
    chk("R3 no limit yet", limit_o, 0);
    chk("R3 drv still on", drv_en_o, 1);
    tick(); chk("R3 limit after 3 edges", limit_o, 1);
    chk("R3 drv on in limit", drv_en_o, 1);
    chk("R10 fault set by oc", fault_o, 1);
    run_hi_limit(n); chk("R3 limit length", n, L);
    run_lo_drv(n);   chk("R4 cool length", n, OFF);
    chk("R4 drv back on", drv_en_o, 1);
    // R5 repeated cycles
    for (int k = 0; k < 3; k++) begin
      tick(); chk("R5 re-limit", limit_o, 1);
      if (k == 2) begin
        clr_pulse(); chk("R10 clear refused", fault_o, 1);
        n = 1 + 1;
        run_hi_limit(n); n = n + 1;
      end else begin
        run_hi_limit(n);
      end
      chk("R5 limit length", n, L);
      run_lo_drv(n); chk("R5 cool length", n, OFF);
    end
    // R6 drop during cool
    tick(); chk("R5 limit again", limit_o, 1);
    tick(L + 5); chk("R6 in cool", drv_en_o, 0);
    cmd_on_i = 1'b0; oc_raw_i = 1'b0; tick(); tick(OFF);
    chk("R6 stays off after cool", drv_en_o, 0);
    clr_pulse(); chk("R10 clear accepted", fault_o, 0);
    // R6 drop at each point of the limit window
    for (int k = 0; k < L; k++) begin
      cmd_on_i = 1'b1; tick(); oc_raw_i = 1'b1; tick(3);
      chk("R6 limit entered", limit_o, 1);
      tick(k); cmd_on_i = 1'b0; tick();
      chk("R6 drv off", drv_en_o, 0);
      chk("R6 limit off", limit_o, 0);
      oc_raw_i = 1'b0; tick(3);
    end
    clr_pulse();

    // R11 / R7 latch mode
    retry_wr_i = 1'b1; retry_val_i = 1'b0; tick(); retry_wr_i = 1'b0;
    cmd_on_i = 1'b1; tick(); chk("R7 on", drv_en_o, 1);
    oc_raw_i = 1'b1; tick(2); chk("R7 on before sync", drv_en_o, 1);
    tick(); chk("R11 R7 latched off", drv_en_o, 0);
    chk("R7 no limit", limit_o, 0);
    oc_raw_i = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin tick(); n += drv_en_o; end
    chk("R7 held off", n, 0);
    cmd_on_i = 1'b0; tick(); cmd_on_i = 1'b1; tick();
    chk("R7 restored", drv_en_o, 1);
    clr_pulse(); chk("R10 cleared", fault_o, 0);

    // R8 over-temperature from on
    ot_i = 1'b1; tick(); chk("R8 ot off", drv_en_o, 0);
    chk("R10 ot sets fault", fault_o, 1);
    clr_pulse(); chk("R10 clear refused ot", fault_o, 1);
    tick(4); chk("R8 held", drv_en_o, 0);
    ot_i = 1'b0; tick(); chk("R8 one edge", drv_en_o, 0);
    tick(); chk("R8 back on", drv_en_o, 1);
    clr_pulse(); chk("R10 clear after ot", fault_o, 0);
    // R8 over-temperature during limit in retry mode
    retry_wr_i = 1'b1; retry_val_i = 1'b1; tick(); retry_wr_i = 1'b0;
    oc_raw_i = 1'b1; tick(3); chk("R11 retry restored", limit_o, 1);
    ot_i = 1'b1; tick();
    chk("R8 limit killed", limit_o, 0);
    chk("R8 drv killed", drv_en_o, 0);
    oc_raw_i = 1'b0; tick(L + 2);
    chk("R8 no resume", drv_en_o, 0);
    ot_i = 1'b0; tick(2); chk("R8 resume", drv_en_o, 1);

    // R9 oc ignored while off
    cmd_on_i = 1'b0; tick(); clr_pulse();
    oc_raw_i = 1'b1; tick(10);
    chk("R9 no fault", fault_o, 0);
    chk("R9 no limit", limit_o, 0);
    oc_raw_i = 1'b0; tick(3);
    cmd_on_i = 1'b1; tick(2);
    chk("R9 clean start", drv_en_o, 1);
    chk("R9 no stale limit", limit_o, 0);

    finish_run();
  end
endmodule